// File: doc/BRIEF.md
# Timing Line Selector Fanout

This block takes a bus of 23 programmable timing lines from an upstream sequencer and routes four of them, one per output channel, onto three identical output copies each. It also drives three copies of a reference clock indication, chosen between a base-rate strobe and a double-rate strobe. All signals are synchronous to one fast system clock. The two strobes are clock-enable pulses within that clock domain.

The block is configured by one 8-bit clock-control word and four 8-bit channel-control words. These arrive on active-low switch inputs and are copied into shadow registers while a load strobe is high. The clock-control word controls three things. It can retime all channels on the chosen strobe through a programmable delay of 0 to 15 strobe periods. It picks the reference strobe. It can silence the clock copies. Each channel-control word picks one timing line and can silence that channel.

Top module: `tl_selector_fanout`

## Requirements
- R1: A channel whose select value S is between 0 and 22 drives timing line S. Channel c uses select bits 4:0 of its word, taken from switch pins `chSwN[8c+7:8c]`.
- R2: A channel whose select value is between 23 and 31 drives a constant 0.
- R3: The three copies of channel c, `lineOut[3c+2:3c]`, are identical on every cycle.
- R4: Each configuration bit equals the inverse of its switch pin level. An open switch gives pin level 0 and reads as 1.
- R5: Switch pins are copied into the shadow words only on a clock edge where `cfgLoad` is high. At all other edges, pin changes have no effect on the outputs.
- R6: When clock-word bit 0 (retime enable) is 0, each active channel shows the line value from the previous clock edge. This holds whatever the strobes are doing.
- R7: When retime is enabled, the chosen line is captured on each strobe edge and is shifted through a delay chain on the same strobes. The delay depth is clock-word bits 7:4, a value D from 0 to 15. With the strobe held high, a one-cycle input pulse appears on the outputs after D+1 clock edges. Between strobes, the outputs hold their value.
- R8: Clock-word bit 1 selects the reference strobe: 1 selects `baseStb` and 0 selects `dblStb`. The three clock copies follow the selected strobe in the same cycle.
- R9: When clock-word bit 2 is 1, all three clock copies are 0. The timing-line channels are not affected.
- R10: When bit 5 of a channel word is 1, all three copies of that channel are 0, whatever line is selected.
- R11: After a synchronous reset, every channel and every clock copy is 0 until a new configuration is loaded.
- R12: Clock-word bit 3 and channel-word bits 7:6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tLines | input | 23 | Timing lines from the sequencer |
| baseStb | input | 1 | Base-rate clock-enable strobe |
| dblStb | input | 1 | Double-rate clock-enable strobe |
| cfgLoad | input | 1 | Copies the switch pins into the shadow words |
| clkSwN | input | 8 | Clock-control switch pins, active low |
| chSwN | input | 32 | Four channel-control switch words, active low; channel c uses bits 8c+7:8c |
| lineOut | output | 12 | Channel outputs; copy k of channel c is bit 3c+k |
| clkOut | output | 3 | Copies of the selected reference strobe |

## Verification
The hardest state to reach is a retimed channel frozen between sparse strobes, deep inside the delay chain. To reach it, the bench first flushes the chain with zero-valued strobe cycles. It then raises the selected line and issues double-rate strobe pulses several idle cycles apart, with the base strobe held high so that a wrong reference choice would show up. After every pulse and every idle cycle, it checks whether the output has moved. The exact delay for every one of the 16 settings is measured by injecting a single-cycle pulse and recording the edge at which it emerges.

// File: rtl/tl_sfo_pkg.sv
package tl_sfo_pkg;
  localparam int CFG_W = 8;
  localparam int SEL_W = 5;
  localparam int DLY_W = 4;

  // clock-control word field positions
  localparam int CK_RETIME  = 0;
  localparam int CK_SELBASE = 1;
  localparam int CK_MUTE    = 2;
  localparam int CK_DLY_LSB = 4;
  // channel-control word field positions
  localparam int CH_MUTE    = 5;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic             capEn;     // load first stage
    logic             shiftEn;   // advance delay chain
    logic             useDelay;  // take output from programmable tap
    logic [DLY_W-1:0] tap;
    logic             refStb;    // selected reference strobe
    logic             clkOn;     // clock copies enabled
  } dpCtrl_t;
endpackage

// File: rtl/tl_sfo_ctrl.sv
module tl_sfo_ctrl
  import tl_sfo_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfgLoad,
  input  logic [CFG_W-1:0]        clkSwN,
  input  logic [NUM_CH*CFG_W-1:0] chSwN,
  input  logic                    baseStb,
  input  logic                    dblStb,
  output dpCtrl_t                 dpc,
  output logic [SEL_W-1:0]        chSel [NUM_CH],
  output logic [NUM_CH-1:0]       chMute
);
  localparam logic [CFG_W-1:0] CLK_RST = CFG_W'(1 << CK_MUTE);
  localparam logic [CFG_W-1:0] CH_RST  = CFG_W'(1 << CH_MUTE);

  logic [CFG_W-1:0] clkWord;
  logic [CFG_W-1:0] chWord [NUM_CH];
  logic             refStb;

  always_ff @(posedge clk) begin
    if (rst)          clkWord <= CLK_RST;
    else if (cfgLoad) clkWord <= ~clkSwN;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chWord
    always_ff @(posedge clk) begin
      if (rst)          chWord[c] <= CH_RST;
      else if (cfgLoad) chWord[c] <= ~chSwN[c*CFG_W +: CFG_W];
    end
    assign chSel[c]  = chWord[c][SEL_W-1:0];
    assign chMute[c] = chWord[c][CH_MUTE];
  end

  always_comb begin
    refStb       = clkWord[CK_SELBASE] ? baseStb : dblStb;
    dpc.refStb   = refStb;
    dpc.useDelay = clkWord[CK_RETIME];
    dpc.capEn    = clkWord[CK_RETIME] ? refStb : 1'b1;
    dpc.shiftEn  = clkWord[CK_RETIME] & refStb;
    dpc.tap      = clkWord[CK_DLY_LSB +: DLY_W];
    dpc.clkOn    = ~clkWord[CK_MUTE];
  end

  // spare word bits carry no function
  logic [2*NUM_CH:0] unusedBits;
  always_comb begin
    unusedBits[0] = clkWord[3];
    for (int c = 0; c < NUM_CH; c++) unusedBits[1+2*c +: 2] = chWord[c][7:6];
  end
endmodule

// File: rtl/tl_sfo_datapath.sv
module tl_sfo_datapath
  import tl_sfo_pkg::*;
#(
  parameter int NUM_LINES = 23,
  parameter int NUM_CH    = 4,
  parameter int NUM_COPY  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LINES-1:0]         tLines,
  input  dpCtrl_t                      dpc,
  input  logic [SEL_W-1:0]             chSel [NUM_CH],
  input  logic [NUM_CH-1:0]            chMute,
  output logic [NUM_CH*NUM_COPY-1:0]   lineOut,
  output logic [NUM_COPY-1:0]          clkOut
);
  localparam int DEPTH    = 2**DLY_W;
  localparam int SEL_SPAN = 2**SEL_W;

  // lines beyond NUM_LINES read as zero
  logic [SEL_SPAN-1:0] padded;
  assign padded = SEL_SPAN'(tLines);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [DEPTH-1:0] pipe;
    logic             picked;
    logic             tapVal;

    assign picked = padded[chSel[c]];

    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else begin
        if (dpc.capEn)   pipe[0]         <= picked;
        if (dpc.shiftEn) pipe[DEPTH-1:1] <= pipe[DEPTH-2:0];
      end
    end

    assign tapVal = dpc.useDelay ? pipe[dpc.tap] : pipe[0];
    assign lineOut[c*NUM_COPY +: NUM_COPY] = chMute[c] ? '0 : {NUM_COPY{tapVal}};
  end

  assign clkOut = dpc.clkOn ? {NUM_COPY{dpc.refStb}} : '0;
endmodule

// File: rtl/tl_selector_fanout.sv
module tl_selector_fanout
  import tl_sfo_pkg::*;
#(
  parameter int NUM_LINES = 23,
  parameter int NUM_CH    = 4,
  parameter int NUM_COPY  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       tLines,
  input  logic                       baseStb,
  input  logic                       dblStb,
  input  logic                       cfgLoad,
  input  logic [CFG_W-1:0]           clkSwN,
  input  logic [NUM_CH*CFG_W-1:0]    chSwN,
  output logic [NUM_CH*NUM_COPY-1:0] lineOut,
  output logic [NUM_COPY-1:0]        clkOut
);
  dpCtrl_t           dpc;
  logic [SEL_W-1:0]  chSel [NUM_CH];
  logic [NUM_CH-1:0] chMute;

  tl_sfo_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .clkSwN(clkSwN), .chSwN(chSwN),
    .baseStb(baseStb), .dblStb(dblStb), .dpc(dpc), .chSel(chSel), .chMute(chMute)
  );

  tl_sfo_datapath #(.NUM_LINES(NUM_LINES), .NUM_CH(NUM_CH), .NUM_COPY(NUM_COPY)) i_dp (
    .clk(clk), .rst(rst), .tLines(tLines), .dpc(dpc), .chSel(chSel),
    .chMute(chMute), .lineOut(lineOut), .clkOut(clkOut)
  );
endmodule

// File: rtl/tl_sfo_checker.sv
module tl_sfo_checker
  import tl_sfo_pkg::*;
#(
  parameter int NUM_LINES = 23,
  parameter int NUM_CH    = 4,
  parameter int NUM_COPY  = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_LINES-1:0]       tLines,
  input logic                       cfgLoad,
  input logic                       useDelay,
  input logic                       shiftEn,
  input logic                       clkOn,
  input logic [SEL_W-1:0]           chSel [NUM_CH],
  input logic [NUM_CH-1:0]          chMute,
  input logic [NUM_CH*NUM_COPY-1:0] lineOut,
  input logic [NUM_COPY-1:0]        clkOut
);
  logic [2**SEL_W-1:0] padLines;
  logic                pick0;
  assign padLines = (2**SEL_W)'(tLines);
  assign pick0    = padLines[chSel[0]];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3
    a_r3_copies_match: assert property (@(posedge clk) disable iff (rst)
      lineOut[c*NUM_COPY +: NUM_COPY] == {NUM_COPY{lineOut[c*NUM_COPY]}});
    // R10
    a_r10_muted_channel_low: assert property (@(posedge clk) disable iff (rst)
      chMute[c] |-> lineOut[c*NUM_COPY +: NUM_COPY] == '0);
  end

  // R9
  a_r9_clock_muted_low: assert property (@(posedge clk) disable iff (rst)
    !clkOn |-> clkOut == '0);

  // R11
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (lineOut == '0 && clkOut == '0));

  // R6
  a_r6_bypass_one_stage: assert property (@(posedge clk) disable iff (rst)
    (!useDelay && !$past(useDelay) && !chMute[0] && $stable(chSel[0]))
      |-> lineOut[0] == $past(pick0));

  // R7
  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (useDelay && !shiftEn && !cfgLoad) |=> $stable(lineOut));
endmodule

bind tl_selector_fanout tl_sfo_checker #(
  .NUM_LINES(NUM_LINES), .NUM_CH(NUM_CH), .NUM_COPY(NUM_COPY)
) i_chk (
  .clk(clk), .rst(rst), .tLines(tLines), .cfgLoad(cfgLoad),
  .useDelay(dpc.useDelay), .shiftEn(dpc.shiftEn), .clkOn(dpc.clkOn),
  .chSel(chSel), .chMute(chMute), .lineOut(lineOut), .clkOut(clkOut)
);

// File: tb/test_tl_selector_fanout.sv
`timescale 1ns/1ps
module test_tl_selector_fanout;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] tLines = '0;
  logic        baseStb = 1'b0;
  logic        dblStb = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [7:0]  clkSwN = 8'hFF;
  logic [31:0] chSwN = '1;
  logic [11:0] lineOut;
  logic [2:0]  clkOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tl_selector_fanout i_tl_selector_fanout (
    .clk(clk), .rst(rst), .tLines(tLines), .baseStb(baseStb), .dblStb(dblStb),
    .cfgLoad(cfgLoad), .clkSwN(clkSwN), .chSwN(chSwN), .lineOut(lineOut), .clkOut(clkOut)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // words are written in true polarity; the pins get the inverse (R4)
  task automatic loadCfg(input logic [7:0] ck, input logic [7:0] w0, input logic [7:0] w1,
                         input logic [7:0] w2, input logic [7:0] w3);
    clkSwN  = ~ck;
    chSwN   = ~{w3, w2, w1, w0};
    cfgLoad = 1'b1;
    tick();
    cfgLoad = 1'b0;
  endtask

  function automatic logic [11:0] expLines(input logic [22:0] p, input int s0, input int s1,
                                           input int s2, input int s3);
    int s[4] = '{s0, s1, s2, s3};
    logic [11:0] r = '0;
    for (int c = 0; c < 4; c++) begin
      logic b = (s[c] < 23) ? p[s[c]] : 1'b0;
      r[c*3 +: 3] = {3{b}};
    end
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1; tLines = '1; baseStb = 1'b1; dblStb = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R11 lines after reset", 32'(lineOut), 32'h0);
    check("R11 clock after reset", 32'(clkOut), 32'h0);
  endtask

  task automatic t_bypass();
    logic [22:0] pats[3] = '{23'h5A5A5A, 23'h2C3F01, 23'h400021};
    baseStb = 1'b0; dblStb = 1'b0;
    loadCfg(8'h02, 8'd0, 8'd5, 8'd17, 8'd22);
    for (int i = 0; i < 3; i++) begin
      tLines = pats[i];
      tick();
      check("R1 R3 R4 R6 bypass routing", 32'(lineOut), 32'(expLines(pats[i], 0, 5, 17, 22)));
    end
  endtask

  task automatic t_outOfRange();
    loadCfg(8'h02, 8'd23, 8'd27, 8'd31, 8'd22);
    tLines = '1;
    tick();
    check("R2 unmapped selects", 32'(lineOut), 32'h0E00);
  endtask

  task automatic t_ignoredBits();
    loadCfg(8'h0A, 8'hC4, 8'h84, 8'h44, 8'hC9);
    tLines = 23'h000010;
    tick();
    check("R12 spare bits ignored", 32'(lineOut), 32'(expLines(23'h000010, 4, 4, 4, 9)));
  endtask

  task automatic t_chMute();
    loadCfg(8'h02, 8'h04, 8'h24, 8'h3F, 8'h04);
    tLines = 23'h000010;
    tick();
    check("R10 channel inhibit", 32'(lineOut), 32'h0E07);
  endtask

  task automatic t_loadGate();
    loadCfg(8'h02, 8'd1, 8'd2, 8'd3, 8'd4);
    tLines = 23'h00001E;
    tick();
    check("R5 loaded config", 32'(lineOut), 32'hFFF);
    clkSwN = ~8'h04; chSwN = ~32'h20202020;
    repeat (3) tick();
    check("R5 pins ignored without load", 32'(lineOut), 32'hFFF);
    check("R5 clock unchanged without load", 32'(clkOut), 32'h0);
  endtask

  task automatic t_clock();
    loadCfg(8'h02, 8'd1, 8'd1, 8'd1, 8'd1);
    baseStb = 1'b1; dblStb = 1'b0; #1;
    check("R8 base strobe selected", 32'(clkOut), 32'h7);
    baseStb = 1'b0; dblStb = 1'b1; #1;
    check("R8 double strobe not selected", 32'(clkOut), 32'h0);
    loadCfg(8'h00, 8'd1, 8'd1, 8'd1, 8'd1);
    baseStb = 1'b0; dblStb = 1'b1; #1;
    check("R8 double strobe selected", 32'(clkOut), 32'h7);
    loadCfg(8'h06, 8'd1, 8'd1, 8'd1, 8'd1);
    baseStb = 1'b1; dblStb = 1'b1; tLines = 23'h000002;
    tick();
    check("R9 clock copies inhibited", 32'(clkOut), 32'h0);
    check("R9 lines unaffected", 32'(lineOut), 32'hFFF);
  endtask

  task automatic t_delaySweep();
    for (int d = 0; d < 16; d++) begin
      int errs = 0;
      logic [2:0] firstBad = '0;
      loadCfg(8'h03 | 8'(d << 4), 8'd3, 8'd3, 8'd3, 8'd3);
      baseStb = 1'b1; dblStb = 1'b0; tLines = '0;
      repeat (20) tick();
      tLines = 23'h000008;
      for (int k = 1; k <= 20; k++) begin
        tick();
        if (lineOut[2:0] !== ((k == d + 1) ? 3'b111 : 3'b000)) begin
          if (errs == 0) firstBad = lineOut[2:0];
          errs++;
        end
        tLines = '0;
      end
      check($sformatf("R7 delay %0d pulse timing (mismatch count)", d), 32'(errs), 32'h0);
      if (errs != 0) $display("  first mismatched sample %b for delay %0d", firstBad, d);
    end
  endtask

  task automatic t_strobeHold();
    loadCfg(8'h21, 8'd7, 8'd7, 8'h27, 8'd7);
    baseStb = 1'b1; dblStb = 1'b0; tLines = '0;
    repeat (5) begin
      dblStb = 1'b1; tick(); dblStb = 1'b0; tick(); tick();
    end
    tLines = 23'h000080;
    for (int p = 1; p <= 3; p++) begin
      logic [11:0] e = (p == 3) ? 12'hE3F : 12'h000;
      logic [11:0] prev = (p == 3) ? 12'h000 : 12'h000;
      dblStb = 1'b1; tick(); dblStb = 1'b0;
      check($sformatf("R7 R8 after strobe %0d", p), 32'(lineOut), 32'(e));
      tick(); tick();
      check($sformatf("R7 held between strobes %0d", p), 32'(lineOut), 32'(e | prev));
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_outOfRange();
    t_ignoredBits();
    t_chMute();
    t_loadGate();
    t_clock();
    t_delaySweep();
    t_strobeHold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule